// File: doc/BRIEF.md
# Low-Jitter Clock Source Selector

This block picks, from a small set of candidate source clocks, the source and fractional divisor that best produce a requested output rate. A fractional divider does not give a clean rate: its output period alternates between the periods of the two nearest whole divisors. For that reason each candidate is not judged by its average rate. It is judged by a worst-case figure: the average rate, reduced by how far the rate at either neighbouring whole divisor lies from that average. An exact whole divisor from a slow source therefore scores its full rate. An inexact fractional divisor from a slow source gives up a large margin and loses to a fast source.

A request is started with a one-cycle `start` pulse. It carries the wanted rate and one frequency per candidate slot, all in Hz. The block scores the slots one after another. A single bit-serial restoring divider performs every division, four per slot at most. When the scan ends, `done` pulses and the outputs give the chosen slot, the integer and fraction parts of its divisor, and whether the divisor is a whole number. If no slot can be used, a no-solution flag is raised instead.

Top module: `ljsel_top`

## Requirements
- R1: A `start` pulse while idle captures the target and all candidate inputs. `busy` stays high until the scan ends. `done` is then high for exactly one cycle, with `busy` low in that cycle. A `start` pulse, or any input change, while `busy` is high has no effect on the result.
- R2: When a candidate frequency is an exact whole multiple of the target, that candidate reports fraction 0 and `int_mode` = 1, and its deviation is zero. With 19.2 MHz in slot 0 and 500 MHz in slot 1, a 400 kHz target selects slot 0 with divisor 48 in integer mode.
- R3: The divisor of a candidate of frequency F for target T is the 32.12 fixed-point value ceil(F*4096/T). `divi` is its integer part and `frac` is its low 12 bits, so a divisor of exactly 1.0 is valid. The average rate therefore never exceeds T.
- R4: A candidate's score is A minus the larger of (F/DIVI − A) and (A − F/(DIVI+1)). Here A = floor(F*4096/divisor), and both rates are floor quotients. When the fraction is zero the score equals A.
- R5: The chosen candidate has the highest score that does not exceed the target. With slots 19.2 MHz and 500 MHz, a 3.072 MHz target selects the 500 MHz slot in fractional mode with divisor 162 and fraction 3115.
- R6: A slot whose frequency is 0 is skipped. A slot whose divisor integer part is 0 is also skipped.
- R7: When two usable slots have equal scores, the lower slot index is chosen.
- R8: If no slot is usable (all skipped, or target 0), `no_sol` = 1 in the `done` cycle, and `sel_idx`, `divi`, `frac` and `int_mode` are all 0.
- R9: After reset, `busy`, `done`, `no_sol`, `int_mode`, `sel_idx`, `divi` and `frac` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a selection (accepted only while idle) |
| target_hz | input | 32 | Requested output rate in Hz |
| cand_hz | input | 128 | Candidate frequencies, slot i in bits [32*i+31:32*i], 0 = unused |
| busy | output | 1 | Scan in progress |
| done | output | 1 | One-cycle pulse: result valid |
| sel_idx | output | 2 | Chosen slot index |
| divi | output | 32 | Integer part of the chosen divisor |
| frac | output | 12 | Fraction part of the chosen divisor (1/4096 units) |
| int_mode | output | 1 | Chosen divisor has zero fraction |
| no_sol | output | 1 | No usable slot was found |

## Verification
The hardest situation to reach from the ports is an exact score tie between two usable slots. A tie requires two sources whose divisors yield the same worst-case figure to the hertz. The stimulus forces it by giving two slots identical frequencies, once in slots 0/1 and once behind a skipped zero slot, so that the strict-greater update rule decides. A second hard case is a slot that is non-zero yet unusable because its divisor integer part rounds to 0. This is reached with a target far above a tiny source frequency. The bench's own 64-bit model scores every vector, so fractional cases with four mixed sources are compared at full precision.

// File: rtl/ljsel_pkg.sv
package ljsel_pkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_LOAD,
    S_W_RATIO,
    S_W_AVG,
    S_W_LO,
    S_W_HI,
    S_SCORE,
    S_NEXT
  } sel_state_e;

endpackage

// File: rtl/ljsel_div.sv
module ljsel_div #(
  parameter int W = 44
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         go,
  input  logic [W-1:0] num,
  input  logic [W-1:0] den,
  output logic         busy,
  output logic         done,
  output logic [W-1:0] quo,
  output logic [W-1:0] rem
);
  localparam int CW = $clog2(W + 1);
  localparam logic [CW-1:0] CNT_INIT = CW'(W);

  logic [W-1:0]  den_q;
  logic [CW-1:0] cnt;
  logic [W:0]    shifted;
  logic [W+1:0]  trial;
  logic          fits;

  assign shifted = {rem, quo[W-1]};
  assign trial   = {1'b0, shifted} - {2'b00, den_q};
  assign fits    = ~trial[W+1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      done  <= 1'b0;
      quo   <= '0;
      rem   <= '0;
      den_q <= '0;
      cnt   <= '0;
    end else if (go && !busy) begin
      busy  <= 1'b1;
      done  <= 1'b0;
      quo   <= num;
      rem   <= '0;
      den_q <= den;
      cnt   <= CNT_INIT;
    end else if (busy) begin
      rem  <= fits ? trial[W-1:0] : shifted[W-1:0];
      quo  <= {quo[W-2:0], fits};
      cnt  <= cnt - 1'b1;
      done <= (cnt == CW'(1));
      if (cnt == CW'(1)) busy <= 1'b0;
    end else begin
      done <= 1'b0;
    end
  end

  // R3: a finished division leaves a remainder below the divisor
  p_div_rem_r3: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (rem < den_q));

  // R3: the selector never asks for a division by zero
  p_div_den_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (go && !busy) |-> (den != '0));

endmodule

// File: rtl/ljsel_score.sv
module ljsel_score #(
  parameter int NUM_W  = 44,
  parameter int FRAC_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              eval,
  input  logic [NUM_W-1:0]  avg,
  input  logic [NUM_W-1:0]  r_lo,
  input  logic [NUM_W-1:0]  r_hi,
  input  logic [FRAC_W-1:0] frac,
  input  logic [NUM_W-1:0]  target,
  output logic [NUM_W-1:0]  score,
  output logic              fits
);
  function automatic logic [NUM_W-1:0] gap(input logic [NUM_W-1:0] a,
                                           input logic [NUM_W-1:0] b);
    return (a > b) ? (a - b) : '0;
  endfunction

  function automatic logic [NUM_W-1:0] worst_dev(input logic [NUM_W-1:0] a,
                                                 input logic [NUM_W-1:0] lo,
                                                 input logic [NUM_W-1:0] hi,
                                                 input logic [FRAC_W-1:0] f);
    logic [NUM_W-1:0] up;
    logic [NUM_W-1:0] dn;
    up = gap(lo, a);
    dn = gap(a, hi);
    if (f == '0) return '0;
    return (up > dn) ? up : dn;
  endfunction

  logic [NUM_W-1:0] dev;

  assign dev   = worst_dev(avg, r_lo, r_hi, frac);
  assign score = gap(avg, dev);
  assign fits  = (score <= target);

  // R4: the neighbour rates bracket the average of a fractional divisor
  p_dev_order_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (eval && frac != '0) |-> (r_lo >= avg && avg >= r_hi));

  // R4: a score never exceeds its average rate
  p_score_le_avg_r4: assert property (@(posedge clk) disable iff (!rst_n)
    eval |-> (score <= avg));

  // R2: a whole divisor keeps its full average rate
  p_int_no_dev_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (eval && frac == '0) |-> (score == avg));

endmodule

// File: rtl/ljsel_best.sv
module ljsel_best #(
  parameter int NUM_W  = 44,
  parameter int FREQ_W = 32,
  parameter int FRAC_W = 12,
  parameter int IDX_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              upd_req,
  input  logic [NUM_W-1:0]  score,
  input  logic [IDX_W-1:0]  idx,
  input  logic [FREQ_W-1:0] divi,
  input  logic [FRAC_W-1:0] frac,
  output logic              have,
  output logic [IDX_W-1:0]  b_idx,
  output logic [FREQ_W-1:0] b_divi,
  output logic [FRAC_W-1:0] b_frac
);
  logic [NUM_W-1:0] b_score;
  logic             take;

  // strictly greater: an equal score keeps the earlier (lower) slot
  assign take = upd_req && (!have || score > b_score);

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      have    <= 1'b0;
      b_score <= '0;
      b_idx   <= '0;
      b_divi  <= '0;
      b_frac  <= '0;
    end else if (take) begin
      have    <= 1'b1;
      b_score <= score;
      b_idx   <= idx;
      b_divi  <= divi;
      b_frac  <= frac;
    end
  end

  // R7: an equal score leaves the held slot in place
  p_tie_keep_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (have && !clr && upd_req && score == b_score) |=> (b_idx == $past(b_idx)));

  // R5: within one scan the held score only grows
  p_best_grows_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (have && !clr) |=> (b_score >= $past(b_score)));

endmodule

// File: rtl/ljsel_top.sv
module ljsel_top #(
  parameter int NUM_CAND = 4,
  parameter int FREQ_W   = 32,
  parameter int FRAC_W   = 12
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         start,
  input  logic [FREQ_W-1:0]            target_hz,
  input  logic [NUM_CAND*FREQ_W-1:0]   cand_hz,
  output logic                         busy,
  output logic                         done,
  output logic [((NUM_CAND > 1) ? $clog2(NUM_CAND) : 1)-1:0] sel_idx,
  output logic [FREQ_W-1:0]            divi,
  output logic [FRAC_W-1:0]            frac,
  output logic                         int_mode,
  output logic                         no_sol
);
  import ljsel_pkg::*;

  localparam int NUM_W = FREQ_W + FRAC_W;
  localparam int IDX_W = (NUM_CAND > 1) ? $clog2(NUM_CAND) : 1;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_CAND - 1);

  sel_state_e        state;
  logic [IDX_W-1:0]  idx;
  logic [FREQ_W-1:0] tgt_q;
  logic [FREQ_W-1:0] cand_q [NUM_CAND];
  logic [NUM_W-1:0]  n_q, d_q, avg_q, lo_q, hi_q;

  logic              div_go;
  logic [NUM_W-1:0]  div_num, div_den;
  logic              div_busy, div_done;
  logic [NUM_W-1:0]  div_quo, div_rem;

  logic [FREQ_W-1:0] cur_cand;
  logic [NUM_W-1:0]  ratio_ceil;
  logic [FREQ_W-1:0] d_int;
  logic [FRAC_W-1:0] d_frac;
  logic              accept, scan_end, eval;
  logic [NUM_W-1:0]  score;
  logic              fits;
  logic              have;
  logic [IDX_W-1:0]  b_idx;
  logic [FREQ_W-1:0] b_divi;
  logic [FRAC_W-1:0] b_frac;

  assign busy       = (state != S_IDLE);
  assign accept     = (state == S_IDLE) && start;
  assign cur_cand   = cand_q[idx];
  assign ratio_ceil = div_quo + {{(NUM_W-1){1'b0}}, (div_rem != '0)};
  assign d_int      = d_q[NUM_W-1:FRAC_W];
  assign d_frac     = d_q[FRAC_W-1:0];
  assign eval       = (state == S_SCORE);
  assign scan_end   = (state == S_NEXT) && (idx == LAST_IDX);

  ljsel_div #(.W(NUM_W)) u_div (
    .clk(clk), .rst_n(rst_n), .go(div_go), .num(div_num), .den(div_den),
    .busy(div_busy), .done(div_done), .quo(div_quo), .rem(div_rem)
  );

  ljsel_score #(.NUM_W(NUM_W), .FRAC_W(FRAC_W)) u_score (
    .clk(clk), .rst_n(rst_n), .eval(eval), .avg(avg_q), .r_lo(lo_q),
    .r_hi(hi_q), .frac(d_frac), .target({{FRAC_W{1'b0}}, tgt_q}),
    .score(score), .fits(fits)
  );

  ljsel_best #(.NUM_W(NUM_W), .FREQ_W(FREQ_W), .FRAC_W(FRAC_W), .IDX_W(IDX_W)) u_best (
    .clk(clk), .rst_n(rst_n), .clr(accept), .upd_req(eval && fits),
    .score(score), .idx(idx), .divi(d_int), .frac(d_frac), .have(have),
    .b_idx(b_idx), .b_divi(b_divi), .b_frac(b_frac)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      idx     <= '0;
      tgt_q   <= '0;
      for (int i = 0; i < NUM_CAND; i++) cand_q[i] <= '0;
      n_q     <= '0;
      d_q     <= '0;
      avg_q   <= '0;
      lo_q    <= '0;
      hi_q    <= '0;
      div_go  <= 1'b0;
      div_num <= '0;
      div_den <= '0;
    end else begin
      div_go <= 1'b0;
      unique case (state)
        S_IDLE: if (start) begin
          tgt_q <= target_hz;
          for (int i = 0; i < NUM_CAND; i++) cand_q[i] <= cand_hz[i*FREQ_W +: FREQ_W];
          idx   <= '0;
          state <= S_LOAD;
        end
        S_LOAD: begin
          n_q <= {cur_cand, {FRAC_W{1'b0}}};
          if (cur_cand == '0 || tgt_q == '0) begin
            state <= S_NEXT;
          end else begin
            div_go  <= 1'b1;
            div_num <= {cur_cand, {FRAC_W{1'b0}}};
            div_den <= {{FRAC_W{1'b0}}, tgt_q};
            state   <= S_W_RATIO;
          end
        end
        S_W_RATIO: if (div_done) begin
          d_q <= ratio_ceil;
          if (ratio_ceil[NUM_W-1:FRAC_W] == '0) begin
            state <= S_NEXT;
          end else begin
            div_go  <= 1'b1;
            div_num <= n_q;
            div_den <= ratio_ceil;
            state   <= S_W_AVG;
          end
        end
        S_W_AVG: if (div_done) begin
          avg_q <= div_quo;
          if (d_frac == '0) begin
            lo_q  <= div_quo;
            hi_q  <= div_quo;
            state <= S_SCORE;
          end else begin
            div_go  <= 1'b1;
            div_num <= {{FRAC_W{1'b0}}, cur_cand};
            div_den <= {{FRAC_W{1'b0}}, d_int};
            state   <= S_W_LO;
          end
        end
        S_W_LO: if (div_done) begin
          lo_q    <= div_quo;
          div_go  <= 1'b1;
          div_num <= {{FRAC_W{1'b0}}, cur_cand};
          div_den <= {{FRAC_W{1'b0}}, d_int} + 1'b1;
          state   <= S_W_HI;
        end
        S_W_HI: if (div_done) begin
          hi_q  <= div_quo;
          state <= S_SCORE;
        end
        S_SCORE: state <= S_NEXT;
        S_NEXT: begin
          if (idx == LAST_IDX) begin
            state <= S_IDLE;
          end else begin
            idx   <= idx + 1'b1;
            state <= S_LOAD;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      done     <= 1'b0;
      sel_idx  <= '0;
      divi     <= '0;
      frac     <= '0;
      int_mode <= 1'b0;
      no_sol   <= 1'b0;
    end else begin
      done <= scan_end;
      if (scan_end) begin
        sel_idx  <= have ? b_idx  : '0;
        divi     <= have ? b_divi : '0;
        frac     <= have ? b_frac : '0;
        int_mode <= have && (b_frac == '0);
        no_sol   <= !have;
      end
    end
  end

  // R1: the end of a scan is marked by done
  p_done_at_end_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);

  // R1: done is a single-cycle pulse outside the busy phase
  p_done_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy)));

  // R2: integer mode always carries a zero fraction
  p_int_frac_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (done && int_mode) |-> (frac == '0 && !no_sol));

  // R6: an empty slot goes straight to the next one
  p_skip_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_LOAD && cur_cand == '0) |=> (state == S_NEXT && !div_go));

  // R8: no solution leaves every result field at zero
  p_nosol_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (done && no_sol) |-> (sel_idx == '0 && divi == '0 && frac == '0 && !int_mode));

  // R9: nothing is pending right after reset
  p_reset_quiet_r9: assert property (@(posedge clk)
    !$past(rst_n) |-> (!done && !div_busy));

endmodule

// File: tb/ljsel_top_test.sv
module ljsel_top_test;

  typedef struct packed {
    logic [31:0]  t;
    logic [127:0] f;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VECS [NV] = '{
    '{32'd400000,   {32'd0, 32'd0, 32'd500000000, 32'd19200000}},          // R2
    '{32'd3072000,  {32'd0, 32'd0, 32'd500000000, 32'd19200000}},          // R5
    '{32'd2400000,  {32'd0, 32'd0, 32'd19200000, 32'd500000000}},          // R5
    '{32'd400000,   {32'd0, 32'd0, 32'd19200000, 32'd19200000}},           // R7
    '{32'd1000000,  {32'd0, 32'd24000000, 32'd24000000, 32'd0}},           // R6
    '{32'd11289600, {32'd100000000, 32'd54000000, 32'd19200000, 32'd25000000}}, // R4
    '{32'd12288000, {32'd0, 32'd0, 32'd0, 32'd12288000}},                  // R3
    '{32'd0,        {32'd0, 32'd0, 32'd0, 32'd19200000}},                  // R8
    '{32'd10000,    {32'd0, 32'd0, 32'd2, 32'd1}},                         // R8
    '{32'd1411200,  {32'd0, 32'd27000000, 32'd500000000, 32'd19200000}},   // R5
    '{32'd48000,    {32'd0, 32'd0, 32'd0, 32'd0}}                          // R6
  };

  function automatic string tag_of(input int k);
    case (k)
      0: return "R2";
      1, 2, 9: return "R5";
      3: return "R7";
      4, 10: return "R6";
      5: return "R4";
      6: return "R3";
      default: return "R8";
    endcase
  endfunction

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  logic [31:0]  target_hz = '0;
  logic [127:0] cand_hz = '0;
  logic         busy, done, int_mode, no_sol;
  logic [1:0]   sel_idx;
  logic [31:0]  divi;
  logic [11:0]  frac;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  ljsel_top uut (
    .clk(clk), .rst_n(rst_n), .start(start), .target_hz(target_hz),
    .cand_hz(cand_hz), .busy(busy), .done(done), .sel_idx(sel_idx),
    .divi(divi), .frac(frac), .int_mode(int_mode), .no_sol(no_sol)
  );

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // worst-case scoring model in 64-bit arithmetic
  task automatic ref_pick(input longint unsigned t, input logic [127:0] f,
                          output int e_idx, output longint unsigned e_divi,
                          output int e_frac, output bit e_int, output bit e_ns);
    bit have = 0;
    longint unsigned best = 0;
    e_idx = 0; e_divi = 0; e_frac = 0; e_int = 0; e_ns = 1;
    for (int i = 0; i < 4; i++) begin
      longint unsigned fi, n, d, dv, fr, avg, lo, hi, dev, sc;
      fi = longint'(f[32*i +: 32]);
      if (fi == 0 || t == 0) continue;
      n  = fi * 4096;
      d  = (n + t - 1) / t;
      dv = d / 4096;
      fr = d % 4096;
      if (dv == 0) continue;
      avg = n / d;
      dev = 0;
      if (fr != 0) begin
        lo  = fi / dv;
        hi  = fi / (dv + 1);
        dev = ((lo - avg) > (avg - hi)) ? (lo - avg) : (avg - hi);
      end
      sc = (avg > dev) ? avg - dev : 0;
      if (sc <= t && (!have || sc > best)) begin
        have = 1; best = sc;
        e_idx = i; e_divi = dv; e_frac = int'(fr); e_int = (fr == 0); e_ns = 0;
      end
    end
  endtask

  task automatic run(input logic [31:0] t, input logic [127:0] f, output bit got);
    @(negedge clk);
    target_hz = t; cand_hz = f; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    got = 0;
    for (int c = 0; c < 5000; c++) begin
      @(negedge clk);
      if (done) begin got = 1; break; end
    end
  endtask

  task automatic expect_res(input string tag, input bit got, input int e_idx,
                            input longint unsigned e_divi, input int e_frac,
                            input bit e_int, input bit e_ns);
    chk(got, tag, "done seen", longint'(got), 1);
    chk(sel_idx == 2'(e_idx), tag, "sel_idx", longint'(sel_idx), e_idx);
    chk(divi == 32'(e_divi), tag, "divi", longint'(divi), longint'(e_divi));
    chk(frac == 12'(e_frac), tag, "frac", longint'(frac), e_frac);
    chk(int_mode == e_int, tag, "int_mode", longint'(int_mode), longint'(e_int));
    chk(no_sol == e_ns, tag, "no_sol", longint'(no_sol), longint'(e_ns));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    bit got;
    int e_idx, e_frac;
    longint unsigned e_divi;
    bit e_int, e_ns;

    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R9: reset state
    chk(!busy && !done, "R9", "busy/done after reset", longint'({busy, done}), 0);
    chk(sel_idx == 0 && divi == 0 && frac == 0, "R9", "result after reset",
        longint'(divi) + longint'(frac) + longint'(sel_idx), 0);
    chk(!int_mode && !no_sol, "R9", "flags after reset", longint'({int_mode, no_sol}), 0);

    // table walk against the bench model
    for (int k = 0; k < NV; k++) begin
      run(VECS[k].t, VECS[k].f, got);
      ref_pick(longint'(VECS[k].t), VECS[k].f, e_idx, e_divi, e_frac, e_int, e_ns);
      expect_res(tag_of(k), got, e_idx, e_divi, e_frac, e_int, e_ns);
    end

    // R2: 400 kHz from 19.2 MHz slot 0, whole divisor 48
    run(32'd400000, {32'd0, 32'd0, 32'd500000000, 32'd19200000}, got);
    expect_res("R2", got, 0, 48, 0, 1, 0);

    // R5 and R3: 3.072 MHz -> 500 MHz slot, ceil divisor 162 + 3115/4096
    run(32'd3072000, {32'd0, 32'd0, 32'd500000000, 32'd19200000}, got);
    expect_res("R5", got, 1, 162, 3115, 0, 0);
    chk(frac == 12'd3115, "R3", "ceil fraction", longint'(frac), 3115);

    // R7: equal sources behind an empty slot, lower index wins
    run(32'd1000000, {32'd0, 32'd24000000, 32'd24000000, 32'd0}, got);
    expect_res("R7", got, 1, 24, 0, 1, 0);

    // R8: every slot empty
    run(32'd48000, '0, got);
    expect_res("R8", got, 0, 0, 0, 0, 1);

    // R1: done lasts one cycle
    run(32'd400000, {32'd0, 32'd0, 32'd0, 32'd19200000}, got);
    @(negedge clk);
    chk(!done && !busy, "R1", "done single pulse", longint'({done, busy}), 0);

    // R1: start and input changes during busy are ignored
    @(negedge clk);
    target_hz = 32'd3072000;
    cand_hz = {32'd0, 32'd0, 32'd500000000, 32'd19200000};
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy, "R1", "busy after start", longint'(busy), 1);
    repeat (20) @(negedge clk);
    target_hz = 32'd400000;
    cand_hz = {32'd0, 32'd0, 32'd0, 32'd19200000};
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    got = 0;
    for (int c = 0; c < 5000; c++) begin
      @(negedge clk);
      if (done) begin got = 1; break; end
    end
    expect_res("R1", got, 1, 162, 3115, 0, 0);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule